// File: doc/BRIEF.md
# Threshold-Triggered Waveform Capture Controller

This block records a stream of 14-bit ADC samples into a 1024-entry circular buffer and freezes a window around a trigger event. The window has a programmable pre-trigger depth and a programmable total length. A level detector fires when a sample lies beyond a user threshold on the side picked by a polarity input. Software can also start a capture with a force input. Samples arrive on every clock. A spacing value stores one sample every `decim+1` clocks, so a slower stream can be recorded.

Capture starts from reset. The block first stores the pre-trigger number of samples and only then arms the trigger. It keeps storing until the trigger fires. It then stores `cap_size - pre_len` more samples, starting with the first sample stored at or after the trigger cycle, and stops. At that point it raises `cap_ready` and holds the buffer and the trigger address. A readout engine reads the buffer through the read port and pulses `readout_done`. This restarts the pre-fill and re-arms the trigger.

The trigger machine has five states: idle, waiting, holding, releasing and forced-release. After a capture it will not fire again until the input has dropped back below the threshold. After a forced capture it also waits for the force input to be released. A pause input keeps the machine idle. The ADC mid-scale (zero input) code is 0x2000.

Top module: `wave_capture_ctrl`

## Requirements
- R1: While `rst` is high and just after it is released, `cap_ready`, `busy` and `trig_out` are 0, `trig_addr` is 0, and the internal write address and sample spacing counter are 0.
- R2: A sample counts as over threshold when `polarity`=0 and `sample` > `threshold`, or when `polarity`=1 and `sample` < `threshold`. A sample equal to the threshold is never over threshold.
- R3: The trigger cannot fire until `pre_len` samples have been stored since the capture (re)started. Storage runs during the pre-fill and continues while the trigger is armed. Once armed, the trigger first needs a sample that is not over threshold (or force high).
- R4: From the waiting state, an over-threshold sample or `force_cap`=1 fires the trigger in that cycle. `trig_out` is high for exactly the next cycle, and `busy` rises together with it.
- R5: `trig_addr` holds the buffer address of the first sample stored at or after the firing cycle, counted with the write address incrementing modulo 1024 on every stored sample since reset.
- R6: After the trigger, exactly `cap_size - pre_len` samples are stored at `trig_addr` onward. `cap_ready` rises the cycle after the last of them is written, and no more writes occur. `cap_ready` and `trig_addr` stay fixed until `readout_done`. This requires `pre_len < cap_size <= 1024`.
- R7: A sample is stored in cycle k (counted from the first clock after reset) only when k is a multiple of `decim+1`, and only while capturing. The spacing counter runs freely from reset.
- R8: `readout_done`=1 while `cap_ready`=1 clears `cap_ready` on the next edge and restarts the pre-fill at the current write address. `busy` clears one cycle later. If the sample is still over threshold, no new trigger occurs until it has gone back below.
- R9: After a forced capture is re-armed, the trigger stays blocked while `force_cap` remains high. It can fire again only after force has been released.
- R10: With `pause`=1 or `enable`=0 the trigger machine stays idle and no capture completes. After `pause` is released while the sample is over threshold, a below-threshold sample is needed before a trigger.
- R11: The buffer read port returns the 14-bit word at `rd_addr` on `rd_data` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows the trigger machine to leave idle |
| pause | input | 1 | Holds the trigger machine idle |
| force_cap | input | 1 | Software trigger, level sensitive |
| polarity | input | 1 | 0: fire above threshold, 1: fire below threshold |
| threshold | input | 14 | Trigger level in ADC codes (0x2000 is zero input) |
| pre_len | input | 10 | Samples kept before the trigger |
| cap_size | input | 11 | Total window length in samples |
| decim | input | 8 | Clocks between stored samples minus one |
| sample | input | 14 | ADC sample, new every clock |
| readout_done | input | 1 | Readout finished; restart capture |
| rd_addr | input | 10 | Buffer read address |
| rd_data | output | 14 | Buffer word at `rd_addr`, one cycle later |
| cap_ready | output | 1 | Window complete and frozen |
| trig_out | output | 1 | One-cycle trigger pulse |
| busy | output | 1 | Trigger taken and not yet re-armed |
| trig_addr | output | 10 | Address of the first post-trigger sample |

## Verification
The bench goes after the cycle bookkeeping around the trigger. It checks the trigger address with spacing factors where the firing cycle falls between stored samples, and it checks a one-sample post window where firing and completion share an edge. It also checks a full 1024-sample window that wraps the buffer. An off-by-one in these counters shows up as a wrong trigger address, a wrong last stored sample, or `cap_ready` one cycle early or late. The bench also covers the re-arm paths: a re-arm while the level is still high, a force held across re-arm, a threshold crossing during pre-fill, and a pause release while the level is high. A machine that skips the below-threshold requirement would retrigger at once on any of these, and the bench would see an unexpected pulse or completion.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

  typedef enum logic [2:0] {
    TS_IDLE    = 3'd0,
    TS_WAIT    = 3'd1,
    TS_HOLD    = 3'd2,
    TS_RELEASE = 3'd3,
    TS_FORCED  = 3'd4
  } trig_state_t;

  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_ARMED = 2'd1,
    PH_POST  = 2'd2,
    PH_READY = 2'd3
  } phase_t;

endpackage

// File: rtl/wcap_ram.sv
module wcap_ram #(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wcap_trig_fsm.sv
module wcap_trig_fsm
  import wcap_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] threshold,
  input  logic              polarity,
  input  logic              enable,
  input  logic              pause,
  input  logic              force_cap,
  input  logic              armed,
  input  logic              rearm,
  output logic              fire,
  output logic              trig_out,
  output logic              busy,
  output trig_state_t       state
);
  logic over;
  logic was_forced;

  // level detector: strict comparison on the side picked by polarity
  assign over = polarity ? (sample < threshold) : (sample > threshold);

  // firing condition is seen by the store controller in the same cycle
  assign fire = (state == TS_WAIT) && armed && (over || force_cap);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TS_IDLE;
      trig_out   <= 1'b0;
      busy       <= 1'b0;
      was_forced <= 1'b0;
    end else begin
      trig_out <= 1'b0;
      case (state)
        TS_IDLE: begin
          if (!pause && enable && armed && (!over || force_cap))
            state <= TS_WAIT;
        end
        TS_WAIT: begin
          if (fire) begin
            state      <= TS_HOLD;
            trig_out   <= 1'b1;
            busy       <= 1'b1;
            was_forced <= force_cap;
          end
        end
        TS_HOLD: begin
          if (rearm) state <= TS_RELEASE;
        end
        TS_RELEASE: begin
          busy <= 1'b0;
          if (!over && !force_cap) state <= TS_IDLE;
          else if (was_forced)     state <= TS_FORCED;
        end
        TS_FORCED: begin
          if (!force_cap) state <= TS_IDLE;
        end
        default: state <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wcap_store_ctrl.sv
module wcap_store_ctrl
  import wcap_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DECIM_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  pre_len,
  input  logic [ADDR_W:0]    cap_size,
  input  logic [DECIM_W-1:0] decim,
  input  logic               fire,
  input  logic               readout_done,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic               armed,
  output logic               rearm,
  output logic               cap_ready,
  output logic [ADDR_W-1:0]  trig_addr
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t              phase;
  logic [DECIM_W-1:0]  dcnt;
  logic                stb;
  logic [ADDR_W-1:0]   wptr;
  logic [CNT_W-1:0]    fill_cnt;
  logic [CNT_W-1:0]    post_left;
  logic [CNT_W-1:0]    post_len;
  logic [CNT_W-1:0]    pre_ext;

  assign pre_ext  = {1'b0, pre_len};
  assign post_len = cap_size - pre_ext;

  // sample spacing: a store slot every decim+1 clocks, free running
  assign stb = (dcnt == '0);

  always_ff @(posedge clk) begin
    if (rst)      dcnt <= '0;
    else if (stb) dcnt <= decim;
    else          dcnt <= dcnt - 1'b1;
  end

  assign wr_en     = stb && (phase != PH_READY);
  assign wr_addr   = wptr;
  assign armed     = (phase == PH_ARMED);
  assign rearm     = (phase == PH_READY) && readout_done;
  assign cap_ready = (phase == PH_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_FILL;
      wptr      <= '0;
      fill_cnt  <= '0;
      post_left <= '0;
      trig_addr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      case (phase)
        PH_FILL: begin
          if (fill_cnt >= pre_ext) phase <= PH_ARMED;
          else if (stb)            fill_cnt <= fill_cnt + 1'b1;
        end
        PH_ARMED: begin
          if (fire) begin
            trig_addr <= wptr;
            if (stb) begin
              // the sample written in the firing cycle is the first post sample
              if (post_len == ONE) begin
                phase <= PH_READY;
              end else begin
                post_left <= post_len - 1'b1;
                phase     <= PH_POST;
              end
            end else begin
              post_left <= post_len;
              phase     <= PH_POST;
            end
          end
        end
        PH_POST: begin
          if (stb) begin
            post_left <= post_left - 1'b1;
            if (post_left == ONE) phase <= PH_READY;
          end
        end
        PH_READY: begin
          if (readout_done) begin
            phase    <= PH_FILL;
            fill_cnt <= '0;
          end
        end
        default: phase <= PH_FILL;
      endcase
    end
  end
endmodule

// File: rtl/wave_capture_ctrl.sv
module wave_capture_ctrl
  import wcap_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int ADDR_W  = 10,
  parameter int DECIM_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               pause,
  input  logic               force_cap,
  input  logic               polarity,
  input  logic [DATA_W-1:0]  threshold,
  input  logic [ADDR_W-1:0]  pre_len,
  input  logic [ADDR_W:0]    cap_size,
  input  logic [DECIM_W-1:0] decim,
  input  logic [DATA_W-1:0]  sample,
  input  logic               readout_done,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               cap_ready,
  output logic               trig_out,
  output logic               busy,
  output logic [ADDR_W-1:0]  trig_addr
);
  logic              fire;
  logic              armed;
  logic              rearm;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  trig_state_t       trig_state;

  wcap_trig_fsm #(.DATA_W(DATA_W)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .sample    (sample),
    .threshold (threshold),
    .polarity  (polarity),
    .enable    (enable),
    .pause     (pause),
    .force_cap (force_cap),
    .armed     (armed),
    .rearm     (rearm),
    .fire      (fire),
    .trig_out  (trig_out),
    .busy      (busy),
    .state     (trig_state)
  );

  wcap_store_ctrl #(.ADDR_W(ADDR_W), .DECIM_W(DECIM_W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .pre_len      (pre_len),
    .cap_size     (cap_size),
    .decim        (decim),
    .fire         (fire),
    .readout_done (readout_done),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .armed        (armed),
    .rearm        (rearm),
    .cap_ready    (cap_ready),
    .trig_addr    (trig_addr)
  );

  wcap_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (sample),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/wave_capture_ctrl_chk.sv
module wave_capture_ctrl_chk
  import wcap_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DECIM_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pause,
  input logic               readout_done,
  input logic [DECIM_W-1:0] decim,
  input logic               cap_ready,
  input logic               trig_out,
  input logic               busy,
  input logic [ADDR_W-1:0]  trig_addr,
  input logic               wr_en,
  input trig_state_t        trig_state
);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);

  assert_pulse_busy_R4: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> busy);

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cap_ready && !readout_done) |=> cap_ready);

  assert_no_write_ready_R6: assert property (@(posedge clk) disable iff (rst)
    cap_ready |-> !wr_en);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cap_ready && $past(cap_ready)) |-> $stable(trig_addr));

  assert_ready_release_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_ready && readout_done) |=> !cap_ready);

  assert_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (decim != '0)) |=> !wr_en);

  assert_pause_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (trig_state == TS_IDLE && pause) |=> (trig_state == TS_IDLE));
endmodule

bind wave_capture_ctrl wave_capture_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DECIM_W (DECIM_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pause        (pause),
  .readout_done (readout_done),
  .decim        (decim),
  .cap_ready    (cap_ready),
  .trig_out     (trig_out),
  .busy         (busy),
  .trig_addr    (trig_addr),
  .wr_en        (wr_en),
  .trig_state   (trig_state)
);

// File: tb/wave_capture_ctrl_tb.sv
module wave_capture_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIG = 1 << 30;

  typedef struct packed {
    logic        pol;
    logic [13:0] thr;
    logic [9:0]  pre;
    logic [10:0] size;
    logic [7:0]  dec;
    logic        frc;
    logic [15:0] kc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 14'h212C, 10'd16,  11'd64,   8'd0, 1'b0, 16'd40},
    '{1'b1, 14'h1ED4, 10'd8,   11'd20,   8'd0, 1'b0, 16'd30},
    '{1'b0, 14'h2100, 10'd10,  11'd30,   8'd3, 1'b0, 16'd63},
    '{1'b0, 14'h2000, 10'd5,   11'd12,   8'd1, 1'b1, 16'd25},
    '{1'b1, 14'h2200, 10'd0,   11'd1,    8'd0, 1'b0, 16'd12},
    '{1'b0, 14'h2000, 10'd100, 11'd1024, 8'd0, 1'b0, 16'd1100}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, pause = 1'b0, force_cap = 1'b0, polarity = 1'b0;
  logic [13:0] threshold = '0, sample = '0;
  logic [9:0]  pre_len = '0, rd_addr = '0;
  logic [10:0] cap_size = 11'd1;
  logic [7:0]  decim = '0;
  logic        readout_done = 1'b0;
  logic [13:0] rd_data;
  logic        cap_ready, trig_out, busy;
  logic [9:0]  trig_addr;

  int total = 0, bad = 0;
  int k = 0;
  int c_pol, c_thr, c_frc, kc, kend, kc2, done_k, en_v, pause_v;
  int trig_cnt, trig_k, kr;
  bit finished = 0;

  wave_capture_ctrl u_dut (
    .clk(clk), .rst(rst), .enable(enable), .pause(pause), .force_cap(force_cap),
    .polarity(polarity), .threshold(threshold), .pre_len(pre_len), .cap_size(cap_size),
    .decim(decim), .sample(sample), .readout_done(readout_done), .rd_addr(rd_addr),
    .rd_data(rd_data), .cap_ready(cap_ready), .trig_out(trig_out), .busy(busy),
    .trig_addr(trig_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
    end
  endtask

  function automatic bit in_win(int kk);
    return (kk >= kc && kk < kend) || (kk >= kc2);
  endfunction

  // R2: over side depends on polarity; equal to threshold is not over
  function automatic int sval(int kk);
    int m = kk % 100;
    if (!c_frc && in_win(kk)) return c_pol ? (c_thr - 1 - m) : (c_thr + 1 + m);
    return c_pol ? (c_thr + m) : (c_thr - m);
  endfunction

  task automatic drive();
    sample       = 14'(sval(k));
    force_cap    = (c_frc != 0) && in_win(k);
    readout_done = (k == done_k);
    enable       = (en_v != 0);
    pause        = (pause_v != 0);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    k++;
    if (trig_out) begin trig_cnt++; trig_k = k; end
    drive();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic setup(vec_t v);
    rst = 1'b1;
    c_pol = int'(v.pol); c_thr = int'(v.thr); c_frc = int'(v.frc);
    kc = int'(v.kc); kend = BIG; kc2 = BIG; done_k = -1; en_v = 1; pause_v = 0;
    polarity = v.pol; threshold = v.thr; pre_len = v.pre; cap_size = v.size; decim = v.dec;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    k = 0; trig_cnt = 0; trig_k = -1;
    drive();
  endtask

  task automatic wait_ready(int maxc);
    int n = 0;
    while (!cap_ready && n < maxc) begin step(); n++; end
    kr = cap_ready ? k : -1;
  endtask

  task automatic rd(int a, output int d);
    rd_addr = 10'(a);
    step();
    d = int'(rd_data);
  endtask

  task automatic release_readout();
    done_k = k;
    drive();
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d, p, kf, post, kl, ta, r;

    // R1: reset state
    setup(VECS[0]);
    rst = 1'b1;
    steps(2);
    check("R1 cap_ready", int'(cap_ready), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 trig_out", int'(trig_out), 0);
    check("R1 trig_addr", int'(trig_addr), 0);

    // vector table walk
    for (int vi = 0; vi < NV; vi++) begin
      setup(VECS[vi]);
      p    = int'(VECS[vi].dec) + 1;
      kf   = ((kc + p - 1) / p) * p;
      post = int'(VECS[vi].size) - int'(VECS[vi].pre);
      kl   = kf + (post - 1) * p;
      ta   = (kf / p) % 1024;
      wait_ready(8000);
      check("R6 ready cycle", kr, kl + 1);
      check("R4 pulse count", trig_cnt, 1);
      check("R4 pulse cycle", trig_k, kc + 1);
      check("R5 trig_addr", int'(trig_addr), ta);
      rd(ta, d);
      check("R11 trigger sample", d, sval(kf));
      rd((ta + post - 1) % 1024, d);
      check("R6 last post sample", d, sval(kl));
      if (VECS[vi].pre != 0) begin
        rd((ta + 1023) % 1024, d);
        check("R3 pre-trigger sample", d, sval(kf - p));
      end
      if (p > 1 && post > 1) begin
        rd((ta + 1) % 1024, d);
        check("R7 spaced sample", d, sval(kf + p));
      end
      check("R6 ready held", int'(cap_ready), 1);
      release_readout();
      check("R8 ready cleared", int'(cap_ready), 0);
      step();
      check("R8 busy cleared", int'(busy), 0);
    end

    // R10: enable low blocks capture
    setup(VECS[0]);
    en_v = 0; drive();
    steps(200);
    check("R10 enable low ready", int'(cap_ready), 0);
    check("R10 enable low busy", int'(busy), 0);

    // R10: pause holds idle; release with level high needs a dip first
    setup(VECS[0]);
    pause_v = 1; drive();
    steps(200);
    check("R10 paused ready", int'(cap_ready), 0);
    pause_v = 0; drive();
    steps(50);
    check("R10 released while over", trig_cnt, 0);
    kend = k + 1; kc2 = k + 20; drive();
    wait_ready(500);
    check("R10 trigger after dip", int'(trig_addr), kc2 % 1024);

    // R3: crossing during pre-fill does not trigger
    setup('{1'b0, 14'h2000, 10'd200, 11'd210, 8'd0, 1'b0, 16'd50});
    steps(400);
    check("R3 early crossing", trig_cnt, 0);
    kend = k + 1; kc2 = k + 10; drive();
    wait_ready(500);
    check("R3 trig_addr after fill", int'(trig_addr), kc2 % 1024);
    rd((kc2 - 200) % 1024, d);
    check("R3 window start", d, sval(kc2 - 200));

    // R8: re-arm while level still high
    setup('{1'b0, 14'h2000, 10'd4, 11'd10, 8'd0, 1'b0, 16'd30});
    wait_ready(500);
    check("R8 first trig_addr", int'(trig_addr), 30);
    r = k;
    release_readout();
    trig_cnt = 0;
    steps(200);
    check("R8 no retrigger while over", trig_cnt, 0);
    check("R8 no ready while over", int'(cap_ready), 0);
    kend = k + 1; kc2 = k + 40; drive();
    wait_ready(500);
    check("R8 second trig_addr", int'(trig_addr), (36 + kc2 - r - 1) % 1024);
    rd(int'(trig_addr), d);
    check("R8 second trigger sample", d, sval(kc2));

    // R9: force held across re-arm blocks trigger until released
    setup(VECS[3]);
    wait_ready(500);
    release_readout();
    trig_cnt = 0;
    steps(100);
    check("R9 held force no pulse", trig_cnt, 0);
    check("R9 held force no ready", int'(cap_ready), 0);
    check("R9 busy cleared", int'(busy), 0);
    kend = k + 1; drive();
    steps(60);
    check("R9 no spontaneous trigger", int'(cap_ready), 0);
    kc2 = k + 5; drive();
    wait_ready(500);
    check("R9 force accepted again", int'(kr != -1), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule